// File: doc/BRIEF.md
# Card Slave Decode and Cycle Acknowledge Glue

This block is the address glue of a peripheral card on a 32-bit asynchronous processor bus that uses dynamic bus sizing. It watches the top address byte, address bit 8, the address strobe and the card's own bus-grant-acknowledge. It produces two chip selects. One goes to a byte-wide identification PROM and one goes to a network controller's register file. For PROM cycles it returns its own pair of cycle acknowledges, coded for an 8-bit port. The controller returns its own 32-bit-port acknowledges, so the glue leaves the pair floating during controller cycles.

The card answers in the 16 MB window whose top address byte is 0xF9. Inside that window, address bit 8 high selects the PROM and bit 8 low selects the controller. Bits 23 to 9 are not decoded, so both regions repeat across the window. While the card owns the bus as master, the glue drives three bus attribute lines low: address bit 0, the low size bit and function-code bit 1. At all other times these lines float. Tri-state lines are shown as a value plus an output enable. All outputs are registered on the card clock, so each output follows its inputs one clock later.

Top module: `slv_glue`

## Requirements
- R1: While rst_ni is low, both chip selects are high (inactive), and dsack_oe_o and attr_oe_o are low.
- R2: A cycle whose top address byte addr_hi_i is not 0xF9 asserts neither chip select and does not drive dsack_o.
- R3: With addr_hi_i = 0xF9, addr_a8_i = 1, as_ni = 0 and bgack_ni = 1, the next clock sets prom_cs_no = 0, ctrl_cs_no = 1, dsack_oe_o = 1 and dsack_o = 2'b10. Here bit 1 is DSACK1 and is driven high, and bit 0 is DSACK0 and is driven low, which codes a byte port.
- R4: With addr_hi_i = 0xF9, addr_a8_i = 0, as_ni = 0 and bgack_ni = 1, the next clock sets ctrl_cs_no = 0, prom_cs_no = 1 and dsack_oe_o = 0.
- R5: One clock after as_ni is high, both chip selects are high and dsack_oe_o is 0, whatever the address.
- R6: One clock after bgack_ni is low, attr_oe_o = 1 and attr_o = 3'b000 (bit 2 is A0, bit 1 is SIZ0, bit 0 is FC1). One clock after bgack_ni is high, attr_oe_o = 0.
- R7: One clock after bgack_ni is low, neither chip select is asserted and dsack_oe_o is 0, even when the window and the strobe match.
- R8: prom_cs_no and ctrl_cs_no are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_hi_i | input | 8 | Address bits 31..24 |
| addr_a8_i | input | 1 | Address bit 8 |
| as_ni | input | 1 | Address strobe, active low |
| bgack_ni | input | 1 | Bus grant acknowledge, active low |
| prom_cs_no | output | 1 | PROM chip select, active low |
| ctrl_cs_no | output | 1 | Controller register chip select, active low |
| dsack_o | output | 2 | Acknowledge value {DSACK1, DSACK0} |
| dsack_oe_o | output | 1 | Drive enable for dsack_o |
| attr_o | output | 3 | Attribute value {A0, SIZ0, FC1} |
| attr_oe_o | output | 1 | Drive enable for attr_o |

## Verification
The bench tries top bytes that differ from 0xF9 in a single bit, at both the high and the low end. A decoder that drops one address term would then select the card at a wrong address. It sets bit 8 both ways, so a swapped region decode or a wrong acknowledge code shows up as a word-port or floating acknowledge on a PROM read. It raises the strobe after a selected cycle, which catches selects or acknowledges that stay asserted. It also asserts bus-grant-acknowledge with a matching address and strobe: a design that ignores mastership would then select itself and drive the acknowledges, or leave the attribute lines floating.

// File: rtl/slv_glue_pkg.sv
package slv_glue_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PROM = 2'd1,
    SEL_CTRL = 2'd2
  } sel_e;

  localparam int unsigned ADDR_HI_W = 8;
  localparam int unsigned DSACK_W   = 2;
  localparam int unsigned ATTR_W    = 3;

  // {DSACK1, DSACK0}: byte port = 1,0
  localparam logic [DSACK_W-1:0] DSACK_BYTE = 2'b10;
endpackage

// File: rtl/slv_addr_decode.sv
module slv_addr_decode
  import slv_glue_pkg::*;
#(
  parameter logic [ADDR_HI_W-1:0] WIN_TAG  = 8'hF9,
  parameter logic                 PROM_A8  = 1'b1
) (
  input  logic [ADDR_HI_W-1:0] addr_hi_i,
  input  logic                 addr_a8_i,
  input  logic                 as_ni,
  input  logic                 bgack_ni,
  output sel_e                 sel_o
);
  logic win_hit;

  // the card's own master cycles never select its slave side
  assign win_hit = (addr_hi_i == WIN_TAG) && !as_ni && bgack_ni;

  always_comb begin
    sel_o = SEL_NONE;
    if (win_hit) begin
      if (addr_a8_i == PROM_A8) sel_o = SEL_PROM;
      else                      sel_o = SEL_CTRL;
    end
  end
endmodule

// File: rtl/slv_ack_drive.sv
module slv_ack_drive
  import slv_glue_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  sel_e               sel_i,
  output logic               prom_cs_no,
  output logic               ctrl_cs_no,
  output logic [DSACK_W-1:0] dsack_o,
  output logic               dsack_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prom_cs_no <= 1'b1;
      ctrl_cs_no <= 1'b1;
      dsack_o    <= '1;
      dsack_oe_o <= 1'b0;
    end else begin
      prom_cs_no <= (sel_i != SEL_PROM);
      ctrl_cs_no <= (sel_i != SEL_CTRL);
      dsack_oe_o <= (sel_i == SEL_PROM);
      dsack_o    <= (sel_i == SEL_PROM) ? DSACK_BYTE : '1;
    end
  end

  AST_CS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!prom_cs_no && !ctrl_cs_no)); // R8
  AST_ACK_ONLY_PROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsack_oe_o |-> !prom_cs_no); // R4
endmodule

// File: rtl/slv_attr_drive.sv
module slv_attr_drive
  import slv_glue_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bgack_ni,
  output logic [ATTR_W-1:0] attr_o,
  output logic              attr_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_oe_o <= 1'b0;
      attr_o    <= '0;
    end else begin
      attr_oe_o <= !bgack_ni;
      attr_o    <= '0;
    end
  end

  AST_ATTR_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bgack_ni |=> (attr_oe_o && attr_o == '0)); // R6
  AST_ATTR_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bgack_ni |=> !attr_oe_o); // R6
endmodule

// File: rtl/slv_glue.sv
module slv_glue
  import slv_glue_pkg::*;
#(
  parameter logic [7:0] WIN_TAG = 8'hF9,
  parameter logic       PROM_A8 = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_hi_i,
  input  logic       addr_a8_i,
  input  logic       as_ni,
  input  logic       bgack_ni,
  output logic       prom_cs_no,
  output logic       ctrl_cs_no,
  output logic [1:0] dsack_o,
  output logic       dsack_oe_o,
  output logic [2:0] attr_o,
  output logic       attr_oe_o
);
  sel_e sel;

  slv_addr_decode #(.WIN_TAG(WIN_TAG), .PROM_A8(PROM_A8)) u_dec (
    .addr_hi_i (addr_hi_i),
    .addr_a8_i (addr_a8_i),
    .as_ni     (as_ni),
    .bgack_ni  (bgack_ni),
    .sel_o     (sel)
  );

  slv_ack_drive u_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .prom_cs_no (prom_cs_no),
    .ctrl_cs_no (ctrl_cs_no),
    .dsack_o    (dsack_o),
    .dsack_oe_o (dsack_oe_o)
  );

  slv_attr_drive u_attr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bgack_ni  (bgack_ni),
    .attr_o    (attr_o),
    .attr_oe_o (attr_oe_o)
  );

  AST_WINDOW_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hi_i != WIN_TAG) |=> (prom_cs_no && ctrl_cs_no && !dsack_oe_o)); // R2
  AST_PROM_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hi_i == WIN_TAG && addr_a8_i == PROM_A8 && !as_ni && bgack_ni)
    |=> (!prom_cs_no && dsack_oe_o && dsack_o == 2'b10)); // R3
  AST_STROBE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |=> (prom_cs_no && ctrl_cs_no && !dsack_oe_o)); // R5
  AST_NO_ACK_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bgack_ni |=> (prom_cs_no && ctrl_cs_no && !dsack_oe_o)); // R7
endmodule

// File: tb/slv_glue_tb.sv
module slv_glue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr_hi = 8'h00;
  logic       a8 = 1'b0;
  logic       as_n = 1'b1;
  logic       bgack_n = 1'b1;
  logic       prom_cs_n, ctrl_cs_n, dsack_oe, attr_oe;
  logic [1:0] dsack;
  logic [2:0] attr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic       prom_n;
    logic       ctrl_n;
    logic       ack_oe;
    logic [1:0] ack;
    logic       at_oe;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  slv_glue u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_hi_i(addr_hi), .addr_a8_i(a8),
    .as_ni(as_n), .bgack_ni(bgack_n), .prom_cs_no(prom_cs_n),
    .ctrl_cs_no(ctrl_cs_n), .dsack_o(dsack), .dsack_oe_o(dsack_oe),
    .attr_o(attr), .attr_oe_o(attr_oe)
  );

  task automatic drive(input logic [7:0] hi, input logic b8, input logic asn,
                       input logic bgn, input string tag);
    exp_t e;
    logic hit;
    @(negedge clk);
    addr_hi = hi; a8 = b8; as_n = asn; bgack_n = bgn;
    hit = (hi == 8'hF9) && !asn && bgn;
    e.prom_n = !(hit && b8);
    e.ctrl_n = !(hit && !b8);
    e.ack_oe = hit && b8;
    e.ack    = 2'b10;
    e.at_oe  = !bgn;
    e.tag    = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        logic ok;
        e = q.pop_front();
        ok = (prom_cs_n === e.prom_n) && (ctrl_cs_n === e.ctrl_n) &&
             (dsack_oe === e.ack_oe) && (attr_oe === e.at_oe) &&
             (!e.ack_oe || dsack === e.ack) && (!e.at_oe || attr === 3'b000);
        checks++;
        if (!ok) begin
          fails++;
          $display("FAIL %s: got prom=%b ctrl=%b ackoe=%b ack=%b atoe=%b at=%b exp prom=%b ctrl=%b ackoe=%b ack=%b atoe=%b at=000",
                   e.tag, prom_cs_n, ctrl_cs_n, dsack_oe, dsack, attr_oe, attr,
                   e.prom_n, e.ctrl_n, e.ack_oe, e.ack, e.at_oe);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset, even with a matching cycle on the inputs
    addr_hi = 8'hF9; a8 = 1'b1; as_n = 1'b0; bgack_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (!(prom_cs_n === 1'b1 && ctrl_cs_n === 1'b1 && dsack_oe === 1'b0 && attr_oe === 1'b0)) begin
      fails++;
      $display("FAIL R1: got prom=%b ctrl=%b ackoe=%b atoe=%b exp 1 1 0 0",
               prom_cs_n, ctrl_cs_n, dsack_oe, attr_oe);
    end
    @(negedge clk);
    addr_hi = 8'h00; as_n = 1'b1; bgack_n = 1'b1;
    rst_n = 1'b1;

    drive(8'hF9, 1'b1, 1'b0, 1'b1, "R3 prom read");
    drive(8'hF9, 1'b1, 1'b1, 1'b1, "R5 prom release");
    drive(8'hF9, 1'b0, 1'b0, 1'b1, "R4 ctrl access");
    drive(8'hF9, 1'b0, 1'b1, 1'b1, "R5 ctrl release");
    drive(8'hF9, 1'b1, 1'b0, 1'b1, "R3 back-to-back a");
    drive(8'hF9, 1'b0, 1'b0, 1'b1, "R8 region switch");
    drive(8'hF8, 1'b1, 1'b0, 1'b1, "R2 tag F8");
    drive(8'hFB, 1'b1, 1'b0, 1'b1, "R2 tag FB");
    drive(8'hFD, 1'b0, 1'b0, 1'b1, "R2 tag FD");
    drive(8'h79, 1'b1, 1'b0, 1'b1, "R2 tag 79");
    drive(8'hF1, 1'b0, 1'b0, 1'b1, "R2 tag F1");
    drive(8'hE9, 1'b1, 1'b0, 1'b1, "R2 tag E9");
    drive(8'hF9, 1'b1, 1'b0, 1'b0, "R7 master prom addr");
    drive(8'hF9, 1'b0, 1'b0, 1'b0, "R7 master ctrl addr");
    drive(8'h00, 1'b0, 1'b1, 1'b0, "R6 master idle");
    drive(8'h00, 1'b0, 1'b1, 1'b1, "R6 master released");
    drive(8'hF9, 1'b1, 1'b0, 1'b1, "R3 after mastership");
    for (int i = 0; i < 16; i++)
      drive(8'hF0 + 8'(i), 1'(i & 1), 1'b0, 1'b1, "R2 sweep");
    drive(8'h00, 1'b0, 1'b1, 1'b1, "R5 idle");

    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule